// File: doc/BRIEF.md
# Asymmetric ADC Clock Prescaler

This block derives the converter clock for an analog-to-digital converter from the system clock. Software supplies a high-time count and a low-time count on their own. An optional half-cycle stretch keeps the converter clock high for half a system cycle longer. The period in system clocks is (high count + 1) + (low count + 1), which gives divide ratios from 2 to 40 with the default field widths. Settings arrive through a write strobe. They are held in a shadow stage and move into the working registers only when a new high phase begins, so a period in progress always finishes with the settings it started with.

Each converter-clock rise also advances a binary divider. A tap-select code picks one divider stage, and every rising transition of that stage produces a one-system-cycle trigger strobe for the conversion queues. A write can land while the queues are still running. The block accepts it, but it also sets a sticky warning flag, because such a write may corrupt a conversion in flight.

Top module: `adc_clk_prescaler`

## Requirements
- R1: After reset the converter clock, the rise strobe, the trigger strobe and the warning flag are all low. The working settings are high count 1, low count 0 and stretch off, so the first converter period after reset lasts 3 system clocks.
- R2: With the stretch off, the converter clock stays high for exactly (high count + 1) system clocks and then low for exactly (low count + 1) system clocks.
- R3: With the stretch on, the converter clock stays high for half a system cycle past the rising system edge that ends the high phase. It falls on the following falling system edge, and the full period length does not change.
- R4: A write takes effect at the start of the next high phase. The period in progress completes with its old high and low lengths.
- R5: The rise strobe is high for exactly one system clock, in the first system cycle of every converter high phase.
- R6: The period covers the full range from 2 system clocks (high 0, low 0) to 40 system clocks (high 31, low 7).
- R7: The divider counts rise strobes. A tap code s in 1..N, where N = stages − first tap + 1, selects divider stage 2^(first tap + s − 1); by default 1 selects 2^7 and 11 selects 2^17. Each rising transition of that stage gives one trigger strobe, one system clock wide, two system clocks after the rise strobe that caused it.
- R8: Tap code 0, or any code above N, produces no trigger strobe.
- R9: A write made while the queues-idle input is low sets the warning flag from the next system clock onward. The flag stays set until reset, and writes made while the queues are idle do not set it.
- R10: Writes are accepted whatever the queues-idle level, and they take effect as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_we | input | 1 | Write strobe for the three setting fields |
| cfg_hi_time | input | HI_W | High-phase count (high time = value + 1 cycles) |
| cfg_lo_time | input | LO_W | Low-phase count (low time = value + 1 cycles) |
| cfg_half_ext | input | 1 | Stretch the high phase by half a system cycle |
| tap_sel | input | TAP_W | Divider tap code, 0 = trigger off |
| queues_idle | input | 1 | High while both conversion queues are disabled |
| conv_clk | output | 1 | Converter clock |
| conv_rise | output | 1 | One-cycle strobe at each converter-clock rise |
| trig_pulse | output | 1 | Periodic trigger strobe |
| unsafe_wr | output | 1 | Sticky flag: a write happened while the queues were running |

## Verification
The bench keeps the default 5-bit high and 3-bit low fields, so the whole 2 to 40 ratio range is exercised. It shrinks the divider to 10 stages with the first tap at stage 2^3. That gives 8 taps, and the highest tap rolls over within a few thousand cycles. Code 9 then lies just past the last valid tap, which makes the out-of-range case reachable. The converter clock is also sampled after each falling system edge, which exposes the half-cycle stretch.

// File: rtl/adc_clk_prescaler_pkg.sv
package adc_clk_prescaler_pkg;
  localparam int unsigned HI_W_DEF       = 5;
  localparam int unsigned LO_W_DEF       = 3;
  localparam int unsigned DIV_STAGES_DEF = 17;
  localparam int unsigned TAP_FIRST_DEF  = 7;
  localparam int unsigned TAP_W_DEF      = 4;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/clkpre_cfg_hold.sv
module clkpre_cfg_hold #(
  parameter int unsigned HI_W = adc_clk_prescaler_pkg::HI_W_DEF,
  parameter int unsigned LO_W = adc_clk_prescaler_pkg::LO_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [HI_W-1:0] cfg_hi_time,
  input  logic [LO_W-1:0] cfg_lo_time,
  input  logic            cfg_half_ext,
  input  logic            queues_idle,
  output logic [HI_W-1:0] shd_hi,
  output logic [LO_W-1:0] shd_lo,
  output logic            shd_half,
  output logic            unsafe_wr
);
  logic [HI_W-1:0] hi_q, hi_n;
  logic [LO_W-1:0] lo_q, lo_n;
  logic            half_q, half_n;
  logic            warn_q, warn_n;

  always_comb begin
    hi_n   = hi_q;
    lo_n   = lo_q;
    half_n = half_q;
    warn_n = warn_q;
    if (cfg_we) begin
      hi_n   = cfg_hi_time;
      lo_n   = cfg_lo_time;
      half_n = cfg_half_ext;
      if (!queues_idle) warn_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= HI_W'(1);
      lo_q   <= '0;
      half_q <= 1'b0;
      warn_q <= 1'b0;
    end else begin
      hi_q   <= hi_n;
      lo_q   <= lo_n;
      half_q <= half_n;
      warn_q <= warn_n;
    end
  end

  assign shd_hi    = hi_q;
  assign shd_lo    = lo_q;
  assign shd_half  = half_q;
  assign unsafe_wr = warn_q;

  p_warn_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    warn_q |=> warn_q);
  p_warn_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_q) |-> $past(cfg_we && !queues_idle));
endmodule

// File: rtl/clkpre_phase_gen.sv
module clkpre_phase_gen
  import adc_clk_prescaler_pkg::*;
#(
  parameter int unsigned HI_W = HI_W_DEF,
  parameter int unsigned LO_W = LO_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HI_W-1:0] shd_hi,
  input  logic [LO_W-1:0] shd_lo,
  input  logic            shd_half,
  output logic            conv_clk,
  output logic            conv_rise
);
  localparam int unsigned CNT_W = (HI_W > LO_W) ? HI_W : LO_W;

  phase_e          phase_q, phase_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [HI_W-1:0] act_hi_q, act_hi_n;
  logic [LO_W-1:0] act_lo_q, act_lo_n;
  logic            act_half_q, act_half_n;
  logic            rise_q, rise_n;
  logic            ext_q;
  logic            last_cnt;

  assign last_cnt = (cnt_q == '0);

  always_comb begin
    phase_n    = phase_q;
    cnt_n      = cnt_q;
    act_hi_n   = act_hi_q;
    act_lo_n   = act_lo_q;
    act_half_n = act_half_q;
    rise_n     = 1'b0;
    if (last_cnt) begin
      if (phase_q == PH_LOW) begin
        phase_n    = PH_HIGH;
        cnt_n      = CNT_W'(shd_hi);
        act_hi_n   = shd_hi;
        act_lo_n   = shd_lo;
        act_half_n = shd_half;
        rise_n     = 1'b1;
      end else begin
        phase_n = PH_LOW;
        cnt_n   = CNT_W'(act_lo_q);
      end
    end else begin
      cnt_n = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_LOW;
      cnt_q      <= '0;
      act_hi_q   <= HI_W'(1);
      act_lo_q   <= '0;
      act_half_q <= 1'b0;
      rise_q     <= 1'b0;
    end else begin
      phase_q    <= phase_n;
      cnt_q      <= cnt_n;
      act_hi_q   <= act_hi_n;
      act_lo_q   <= act_lo_n;
      act_half_q <= act_half_n;
      rise_q     <= rise_n;
    end
  end

  // Falling-edge flag: armed in the last high cycle, it covers the first
  // half of the following cycle.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= act_half_q & (phase_q == PH_HIGH) & last_cnt;
  end

  assign conv_clk  = (phase_q == PH_HIGH) | ext_q;
  assign conv_rise = rise_q;

  p_rise_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |=> !rise_q);
  p_rise_in_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (phase_q == PH_HIGH));
  p_act_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({act_hi_q, act_lo_q, act_half_q}) |-> rise_q);
  p_cnt_in_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HIGH) |-> (cnt_q <= CNT_W'(act_hi_q)));
  p_cnt_in_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW) |-> (cnt_q <= CNT_W'(act_lo_q)));
  p_ext_needs_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q |-> act_half_q);
endmodule

// File: rtl/clkpre_tap_div.sv
module clkpre_tap_div #(
  parameter int unsigned DIV_STAGES = adc_clk_prescaler_pkg::DIV_STAGES_DEF,
  parameter int unsigned TAP_FIRST  = adc_clk_prescaler_pkg::TAP_FIRST_DEF,
  parameter int unsigned TAP_W      = adc_clk_prescaler_pkg::TAP_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [TAP_W-1:0] tap_sel,
  output logic             trig_pulse
);
  localparam int unsigned NTAP = DIV_STAGES - TAP_FIRST + 1;

  logic [DIV_STAGES-1:0] div_q, div_n;
  logic                  tap_now;
  logic                  tap_prev_q;
  logic                  trig_q, trig_n;

  always_comb begin
    tap_now = 1'b0;
    for (int k = 0; k < int'(NTAP); k++) begin
      if (tap_sel == TAP_W'(k + 1)) tap_now = div_q[TAP_FIRST - 1 + k];
    end
  end

  always_comb begin
    div_n  = step_en ? (div_q + DIV_STAGES'(1)) : div_q;
    trig_n = tap_now & ~tap_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q      <= '0;
      tap_prev_q <= 1'b0;
      trig_q     <= 1'b0;
    end else begin
      div_q      <= div_n;
      tap_prev_q <= tap_now;
      trig_q     <= trig_n;
    end
  end

  assign trig_pulse = trig_q;

  p_trig_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> !trig_q);
  p_trig_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tap_sel) == '0) |-> !trig_q);
  p_div_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(div_q));
endmodule

// File: rtl/adc_clk_prescaler.sv
module adc_clk_prescaler #(
  parameter int unsigned HI_W       = adc_clk_prescaler_pkg::HI_W_DEF,
  parameter int unsigned LO_W       = adc_clk_prescaler_pkg::LO_W_DEF,
  parameter int unsigned DIV_STAGES = adc_clk_prescaler_pkg::DIV_STAGES_DEF,
  parameter int unsigned TAP_FIRST  = adc_clk_prescaler_pkg::TAP_FIRST_DEF,
  parameter int unsigned TAP_W      = adc_clk_prescaler_pkg::TAP_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [HI_W-1:0]  cfg_hi_time,
  input  logic [LO_W-1:0]  cfg_lo_time,
  input  logic             cfg_half_ext,
  input  logic [TAP_W-1:0] tap_sel,
  input  logic             queues_idle,
  output logic             conv_clk,
  output logic             conv_rise,
  output logic             trig_pulse,
  output logic             unsafe_wr
);
  logic [HI_W-1:0] shd_hi;
  logic [LO_W-1:0] shd_lo;
  logic            shd_half;

  clkpre_cfg_hold #(.HI_W(HI_W), .LO_W(LO_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_hi_time(cfg_hi_time), .cfg_lo_time(cfg_lo_time),
    .cfg_half_ext(cfg_half_ext), .queues_idle(queues_idle),
    .shd_hi(shd_hi), .shd_lo(shd_lo), .shd_half(shd_half),
    .unsafe_wr(unsafe_wr)
  );

  clkpre_phase_gen #(.HI_W(HI_W), .LO_W(LO_W)) u_phase (
    .clk(clk), .rst_n(rst_n),
    .shd_hi(shd_hi), .shd_lo(shd_lo), .shd_half(shd_half),
    .conv_clk(conv_clk), .conv_rise(conv_rise)
  );

  clkpre_tap_div #(.DIV_STAGES(DIV_STAGES), .TAP_FIRST(TAP_FIRST), .TAP_W(TAP_W)) u_div (
    .clk(clk), .rst_n(rst_n), .step_en(conv_rise),
    .tap_sel(tap_sel), .trig_pulse(trig_pulse)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!conv_rise && !trig_pulse && !unsafe_wr));
endmodule

// File: tb/adc_clk_prescaler_tb_top.sv
`timescale 1ns/1ps
module adc_clk_prescaler_tb_top;
  localparam int HI_W = 5, LO_W = 3, STG = 10, TF = 3, TW = 4;
  localparam int NTAP = STG - TF + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_half_ext, queues_idle;
  logic [HI_W-1:0] cfg_hi_time;
  logic [LO_W-1:0] cfg_lo_time;
  logic [TW-1:0] tap_sel;
  logic conv_clk, conv_rise, trig_pulse, unsafe_wr;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  int m_pos, m_len, m_hi, m_lo, m_half, s_hi, s_lo, s_half;
  int m_rise, m_div, m_tprev, m_trig, m_warn;
  int cyc = 0, last_rise = 0, last_period = 0, trig_cnt = 0;

  adc_clk_prescaler #(.HI_W(HI_W), .LO_W(LO_W), .DIV_STAGES(STG), .TAP_FIRST(TF), .TAP_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hi_time(cfg_hi_time),
    .cfg_lo_time(cfg_lo_time), .cfg_half_ext(cfg_half_ext), .tap_sel(tap_sel),
    .queues_idle(queues_idle), .conv_clk(conv_clk), .conv_rise(conv_rise),
    .trig_pulse(trig_pulse), .unsafe_wr(unsafe_wr)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int tapbit(int d, int s);
    if (s >= 1 && s <= NTAP) return (d >> (TF - 2 + s)) & 1;
    return 0;
  endfunction

  task automatic model_reset();
    m_hi = 1; m_lo = 0; m_half = 0; m_len = 3; m_pos = 2;
    s_hi = 1; s_lo = 0; s_half = 0;
    m_rise = 0; m_div = 0; m_tprev = 0; m_trig = 0; m_warn = 0;
  endtask

  task automatic model_step();
    int nt, tb;
    tb = tapbit(m_div, int'(tap_sel));
    nt = (tb == 1 && m_tprev == 0) ? 1 : 0;
    m_tprev = tb;
    if (m_rise == 1) m_div = (m_div + 1) % (1 << STG);
    m_trig = nt;
    m_pos++;
    if (m_pos == m_len) begin
      m_pos = 0; m_hi = s_hi; m_lo = s_lo; m_half = s_half;
      m_len = m_hi + m_lo + 2; m_rise = 1;
    end else m_rise = 0;
    if (cfg_we) begin
      s_hi = int'(cfg_hi_time); s_lo = int'(cfg_lo_time); s_half = int'(cfg_half_ext);
      if (!queues_idle) m_warn = 1;
    end
  endtask

  always @(posedge clk) begin
    int e;
    if (!rst_n) model_reset(); else model_step();
    #1.25;
    cyc++;
    if (conv_rise) begin last_period = cyc - last_rise; last_rise = cyc; end
    if (trig_pulse) trig_cnt++;
    e = ((m_pos <= m_hi) || (m_half == 1 && m_pos == m_hi + 1)) ? 1 : 0;
    chk(conv_clk == e[0], "R2/R3 conv_clk early half", conv_clk, e);
    chk(conv_rise == m_rise[0], "R5 rise strobe", conv_rise, m_rise);
    chk(trig_pulse == m_trig[0], "R7 trigger strobe", trig_pulse, m_trig);
    chk(unsafe_wr == m_warn[0], "R9 warning flag", unsafe_wr, m_warn);
    #2.5;
    e = (m_pos <= m_hi) ? 1 : 0;
    chk(conv_clk == e[0], "R3 conv_clk late half", conv_clk, e);
  end

  task automatic wr(input int hi, input int lo, input int half, input bit idle);
    @(negedge clk);
    cfg_hi_time = HI_W'(hi); cfg_lo_time = LO_W'(lo); cfg_half_ext = half[0];
    queues_idle = idle; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; queues_idle = 1'b1;
  endtask

  task automatic wait_rises(input int n);
    int c = 0;
    while (c < n) begin
      @(negedge clk);
      if (conv_rise) c++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_hi_time = '0; cfg_lo_time = '0;
    cfg_half_ext = 1'b0; tap_sel = '0; queues_idle = 1'b1;
    repeat (3) @(negedge clk);
    chk(conv_clk == 1'b0, "R1 reset conv_clk", conv_clk, 0);
    chk(conv_rise == 1'b0, "R1 reset rise", conv_rise, 0);
    chk(trig_pulse == 1'b0, "R1 reset trigger", trig_pulse, 0);
    chk(unsafe_wr == 1'b0, "R1 reset warning", unsafe_wr, 0);
    rst_n = 1'b1;
    wait_rises(3);
    chk(last_period == 3, "R1 default period", last_period, 3);

    wr(4, 2, 0, 1'b1); wait_rises(3);
    chk(last_period == 8, "R2 period 4/2", last_period, 8);
    wr(0, 0, 0, 1'b1); wait_rises(3);
    chk(last_period == 2, "R6 minimum period", last_period, 2);
    wr(31, 7, 0, 1'b1); wait_rises(3);
    chk(last_period == 40, "R6 maximum period", last_period, 40);

    wr(2, 1, 0, 1'b1); wait_rises(1);
    chk(last_period == 40, "R4 old period completes", last_period, 40);
    wait_rises(1);
    chk(last_period == 5, "R4 new period applied", last_period, 5);

    wr(3, 2, 1, 1'b1); wait_rises(4);
    chk(last_period == 7, "R3 stretch keeps period", last_period, 7);
    wr(0, 0, 1, 1'b1); wait_rises(4);
    chk(last_period == 2, "R3 stretch at minimum", last_period, 2);

    chk(unsafe_wr == 1'b0, "R9 no warning after idle writes", unsafe_wr, 0);
    wr(5, 1, 0, 1'b0);
    chk(unsafe_wr == 1'b1, "R9 warning after busy write", unsafe_wr, 1);
    wait_rises(3);
    chk(last_period == 8, "R10 busy write accepted", last_period, 8);
    wr(0, 0, 0, 1'b1);
    chk(unsafe_wr == 1'b1, "R9 warning sticky", unsafe_wr, 1);
    wait_rises(3);

    tap_sel = TW'(0); trig_cnt = 0;
    repeat (600) @(negedge clk);
    chk(trig_cnt == 0, "R8 tap code 0 silent", trig_cnt, 0);
    tap_sel = TW'(1); trig_cnt = 0;
    repeat (640) @(negedge clk);
    chk(trig_cnt >= 39 && trig_cnt <= 41, "R7 lowest tap rate", trig_cnt, 40);
    tap_sel = TW'(NTAP); trig_cnt = 0;
    repeat (4200) @(negedge clk);
    chk(trig_cnt >= 1 && trig_cnt <= 3, "R7 highest tap rate", trig_cnt, 2);
    tap_sel = TW'(NTAP + 1); trig_cnt = 0;
    repeat (2200) @(negedge clk);
    chk(trig_cnt == 0, "R8 out-of-range tap silent", trig_cnt, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule